// File: doc/BRIEF.md
# Addressed Frame Receiver with CRC Check

This block sits on the receive side of a slave node attached to a one-way broadcast write bus. Every node sees every frame. Bytes arrive one per accepted cycle. A start strobe marks the first byte of a frame and an end strobe marks the last. The block parses the frame header and keeps only frames whose 16-bit destination matches the node's configured address. It stores the payload of a kept frame in a small receive FIFO, staged and not yet visible to the reader. It runs a CRC-32 over the frame while the bytes arrive.

When the final byte arrives, the block compares the computed CRC with the received check field:
- On a match, a `frame_ok` pulse carries the decoded frame kind, the sender address and the payload length, and the staged bytes become readable.
- On a mismatch, a `crc_error` pulse carries the sender address. The local transmit side uses it as a request to send a resend-request frame. The staged bytes are thrown away.

Malformed frames are dropped silently, and any bytes they staged are withdrawn. A frame is malformed if it has a bad length, an unknown kind, a misplaced end strobe or a buffer overflow.

Top module: `addr_frame_rx`

## Requirements
- R1: Frame bytes arrive in this order, each multi-byte field most-significant byte first: destination (2 bytes), source (2), kind (1), length (2), payload (length bytes), check (4). On `frame_ok`, `rx_src` equals the source field and `rx_len` equals the length field.
- R2: A frame whose destination differs from `local_addr` produces no pulse and leaves the buffer empty of its bytes.
- R3: For an accepted frame, the payload bytes and nothing else are readable from the buffer, in arrival order. They become readable in the same cycle as `frame_ok`.
- R4: The CRC is CRC-32 with polynomial 0x04C11DB7, initial value 0xFFFFFFFF, no reflection and no final inversion. It covers every byte from the first destination byte through the last payload byte. When it equals the check field, `frame_ok` is high for exactly the one cycle after the edge that takes the final byte.
- R5: On a CRC mismatch, `crc_error` (the resend request) pulses in that same cycle with `rx_src` set to the sender. `frame_ok` stays low, and none of the frame's bytes become readable.
- R6: Kind byte 0x01 (write data) gives `rx_kind`=1, 0x02 (read command) gives 2, and 0x03 (send again) gives 3. Any other kind byte drops the frame with no pulse.
- R7: A length of 0 or greater than 2048 drops the frame with no pulse and no stored bytes.
- R8: An end strobe before the fourth check byte, or a fourth check byte without an end strobe, drops the frame with no pulse and no stored bytes.
- R9: A start strobe in the middle of a frame abandons the partial frame, withdrawing any staged bytes, and begins parsing a new frame with that byte.
- R10: A payload byte that arrives while the buffer is full drops the frame with no pulse and no stored bytes.
- R11: After reset, both pulses are low and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_addr | input | 16 | Address of this node |
| in_valid | input | 1 | Byte present this cycle |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_byte | input | 8 | Frame byte |
| rd_en | input | 1 | Pop one committed byte |
| rd_data | output | 8 | Oldest committed byte |
| buf_empty | output | 1 | No committed byte available |
| frame_ok | output | 1 | One-cycle pulse: frame accepted |
| crc_error | output | 1 | One-cycle pulse: CRC mismatch, resend needed |
| rx_kind | output | 2 | Decoded kind of the last reported frame |
| rx_src | output | 16 | Source address of the last reported frame |
| rx_len | output | 12 | Payload length of the last reported frame |

## Verification
Each result (`frame_ok`, `crc_error`, the reported fields, and the change of `buf_empty` at commit) is due one register stage after the clock edge that takes the final byte. The bench drives each byte on a falling edge and samples the outputs at the falling edge straight after the final byte. It looks again one cycle later to confirm that the pulse has dropped. Buffer contents are then popped one byte per cycle through the read port and compared with the payload the bench generated. Dropped frames are checked by finding `buf_empty` still set after them.

// File: rtl/afr_pkg.sv
package afr_pkg;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;

  typedef enum logic [1:0] {
    K_NONE   = 2'd0,
    K_WRITE  = 2'd1,
    K_READ   = 2'd2,
    K_RESEND = 2'd3
  } kind_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HDR,
    S_DATA,
    S_CHK,
    S_SKIP
  } pstate_t;

  // One byte of MSB-first CRC-32, no reflection.
  function automatic logic [31:0] crc32_step(logic [31:0] c, logic [7:0] d);
    logic [31:0] r;
    r = c ^ {d, 24'h000000};
    for (int i = 0; i < 8; i++) begin
      r = r[31] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction

  function automatic kind_t kind_of(logic [7:0] t);
    case (t)
      8'h01:   return K_WRITE;
      8'h02:   return K_READ;
      8'h03:   return K_RESEND;
      default: return K_NONE;
    endcase
  endfunction
endpackage

// File: rtl/afr_crc32.sv
module afr_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);
  import afr_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)     crc <= CRC_INIT;
    else if (start) crc <= crc32_step(CRC_INIT, din);
    else if (en)    crc <= crc32_step(crc, din);
  end
endmodule

// File: rtl/afr_commit_fifo.sv
module afr_commit_fifo #(
  parameter int DEPTH = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       commit,
  input  logic       rollback,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       empty,
  output logic       full
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]  mem [DEPTH];
  logic [AW:0] wr_ptr, cmt_ptr, rd_ptr;
  logic [AW:0] used;

  assign used    = wr_ptr - rd_ptr;
  assign full    = (used == (AW+1)'(DEPTH));
  assign empty   = (cmt_ptr == rd_ptr);
  assign rd_data = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      cmt_ptr <= '0;
      rd_ptr  <= '0;
    end else begin
      if (rollback)   wr_ptr <= cmt_ptr;
      else if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (commit)     cmt_ptr <= wr_ptr;
      if (rd_en && !empty) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full); // R10
  AST_COMMIT_ONLY_ON_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_ptr != $past(cmt_ptr)) |-> $past(commit)); // R3
  AST_COMMIT_XOR_ROLLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && rollback)); // R5
endmodule

// File: rtl/afr_parser.sv
module afr_parser #(
  parameter int MAX_LEN = 2048,
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   local_addr,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [7:0]    in_byte,
  input  logic [31:0]   crc_val,
  input  logic          buf_full,
  output logic          crc_start,
  output logic          crc_en,
  output logic          wr_en,
  output logic          commit,
  output logic          rollback,
  output logic          frame_ok,
  output logic          crc_error,
  output logic [1:0]    rx_kind,
  output logic [15:0]   rx_src,
  output logic [LW-1:0] rx_len
);
  import afr_pkg::*;

  pstate_t       st;
  logic [2:0]    idx;
  logic [7:0]    da_hi, len_hi;
  logic [15:0]   sa;
  kind_t         kind;
  logic [LW-1:0] len_q, rem;
  logic [23:0]   chk;

  // Named per-byte events, shared by the state update and the assertions.
  logic        acc, ev_restart, ev_mismatch, ev_badtype, ev_badlen;
  logic        ev_end, crc_good, ev_abort;
  logic [15:0] len_full;

  always_comb begin
    acc         = in_valid && !in_sof;
    ev_restart  = in_valid && in_sof;
    len_full    = {len_hi, in_byte};
    ev_mismatch = acc && st == S_HDR && !in_eof && idx == 3'd1 &&
                  ({da_hi, in_byte} != local_addr);
    ev_badtype  = acc && st == S_HDR && !in_eof && idx == 3'd4 &&
                  kind_of(in_byte) == K_NONE;
    ev_badlen   = acc && st == S_HDR && !in_eof && idx == 3'd6 &&
                  (len_full == 16'd0 || 32'(len_full) > MAX_LEN);
    ev_end      = acc && st == S_CHK && idx == 3'd3 && in_eof;
    crc_good    = ({chk, in_byte} == crc_val);
    ev_abort    = acc && ((st == S_HDR && in_eof) ||
                          (st == S_DATA && (in_eof || buf_full)) ||
                          (st == S_CHK && (in_eof != (idx == 3'd3))));
    crc_start   = ev_restart;
    crc_en      = acc && !in_eof &&
                  (st == S_HDR || (st == S_DATA && !buf_full));
    wr_en       = acc && st == S_DATA && !in_eof && !buf_full;
    commit      = ev_end && crc_good;
    rollback    = ev_restart || ev_abort || (ev_end && !crc_good);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      da_hi     <= '0;
      len_hi    <= '0;
      sa        <= '0;
      kind      <= K_NONE;
      len_q     <= '0;
      rem       <= '0;
      chk       <= '0;
      frame_ok  <= 1'b0;
      crc_error <= 1'b0;
    end else begin
      frame_ok  <= 1'b0;
      crc_error <= 1'b0;
      if (ev_restart) begin
        st    <= in_eof ? S_IDLE : S_HDR;
        idx   <= 3'd1;
        da_hi <= in_byte;
      end else if (acc) begin
        case (st)
          S_HDR: begin
            if (in_eof) st <= S_IDLE;
            else begin
              idx <= idx + 3'd1;
              case (idx)
                3'd1: if (ev_mismatch) st <= S_SKIP;
                3'd2: sa[15:8] <= in_byte;
                3'd3: sa[7:0]  <= in_byte;
                3'd4: if (ev_badtype) st <= S_SKIP;
                      else kind <= kind_of(in_byte);
                3'd5: len_hi <= in_byte;
                default: begin
                  if (ev_badlen) st <= S_SKIP;
                  else begin
                    len_q <= len_full[LW-1:0];
                    rem   <= len_full[LW-1:0];
                    st    <= S_DATA;
                  end
                end
              endcase
            end
          end
          S_DATA: begin
            if (in_eof)        st <= S_IDLE;
            else if (buf_full) st <= S_SKIP;
            else begin
              rem <= rem - 1'b1;
              if (rem == LW'(1)) begin
                st  <= S_CHK;
                idx <= 3'd0;
              end
            end
          end
          S_CHK: begin
            if (in_eof) begin
              st <= S_IDLE;
              if (idx == 3'd3) begin
                frame_ok  <= crc_good;
                crc_error <= !crc_good;
              end
            end else if (idx == 3'd3) begin
              st <= S_SKIP;
            end else begin
              chk <= {chk[15:0], in_byte};
              idx <= idx + 3'd1;
            end
          end
          S_SKIP: if (in_eof) st <= S_IDLE;
          default: ;
        endcase
      end
    end
  end

  assign rx_kind = kind;
  assign rx_src  = sa;
  assign rx_len  = len_q;

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok && crc_error)); // R5
  AST_SKIP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |-> !wr_en); // R2
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> (rx_len != '0 && 32'(rx_len) <= MAX_LEN)); // R7
  AST_KIND_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> (rx_kind != K_NONE)); // R6
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !frame_ok); // R4
endmodule

// File: rtl/addr_frame_rx.sv
module addr_frame_rx #(
  parameter int MAX_LEN = 2048,
  parameter int DEPTH   = 2048
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [15:0]                  local_addr,
  input  logic                         in_valid,
  input  logic                         in_sof,
  input  logic                         in_eof,
  input  logic [7:0]                   in_byte,
  input  logic                         rd_en,
  output logic [7:0]                   rd_data,
  output logic                         buf_empty,
  output logic                         frame_ok,
  output logic                         crc_error,
  output logic [1:0]                   rx_kind,
  output logic [15:0]                  rx_src,
  output logic [$clog2(MAX_LEN+1)-1:0] rx_len
);
  logic [31:0] crc_val;
  logic        crc_start, crc_en, wr_en, commit, rollback, buf_full;

  afr_parser #(.MAX_LEN(MAX_LEN)) u_parser (
    .clk(clk), .rst_n(rst_n), .local_addr(local_addr),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_byte(in_byte),
    .crc_val(crc_val), .buf_full(buf_full),
    .crc_start(crc_start), .crc_en(crc_en), .wr_en(wr_en),
    .commit(commit), .rollback(rollback),
    .frame_ok(frame_ok), .crc_error(crc_error),
    .rx_kind(rx_kind), .rx_src(rx_src), .rx_len(rx_len)
  );

  afr_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .start(crc_start), .en(crc_en),
    .din(in_byte), .crc(crc_val)
  );

  afr_commit_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(in_byte),
    .commit(commit), .rollback(rollback), .rd_en(rd_en),
    .rd_data(rd_data), .empty(buf_empty), .full(buf_full)
  );
endmodule

// File: tb/tb_addr_frame_rx.sv
`timescale 1ns/1ps
module tb_addr_frame_rx;
  localparam logic [15:0] MY_ADDR = 16'hA5C3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 0, in_sof = 0, in_eof = 0, rd_en = 0;
  logic [7:0]  in_byte = '0;
  logic [7:0]  rd_data;
  logic        buf_empty, frame_ok, crc_error;
  logic [1:0]  rx_kind;
  logic [15:0] rx_src;
  logic [11:0] rx_len;

  always #2.5 clk = ~clk;

  addr_frame_rx #(.MAX_LEN(2048), .DEPTH(16)) dut (
    .clk(clk), .rst_n(rst_n), .local_addr(MY_ADDR),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_byte(in_byte),
    .rd_en(rd_en), .rd_data(rd_data), .buf_empty(buf_empty),
    .frame_ok(frame_ok), .crc_error(crc_error),
    .rx_kind(rx_kind), .rx_src(rx_src), .rx_len(rx_len)
  );

  int checks = 0, fails = 0;
  logic [7:0] fr [64];
  int fr_n;

  typedef struct packed {
    logic [15:0] da;
    logic [15:0] sa;
    logic [7:0]  typ;
    logic [15:0] len;
    logic [7:0]  seed;
    logic        bad_crc;
    logic [1:0]  outcome;   // 0 dropped, 1 frame_ok, 2 crc_error
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{16'hA5C3, 16'h1234, 8'h01, 16'd4,  8'd10, 1'b0, 2'd1}, // R1 R3 R4
    '{16'hA5C3, 16'hBEEF, 8'h02, 16'd1,  8'd77, 1'b0, 2'd1}, // R6 read
    '{16'hA5C3, 16'h0F0F, 8'h03, 16'd16, 8'd3,  1'b0, 2'd1}, // R6 resend, full buffer
    '{16'hA5C2, 16'h1111, 8'h01, 16'd5,  8'd9,  1'b0, 2'd0}, // R2 low byte
    '{16'h25C3, 16'h1111, 8'h01, 16'd5,  8'd9,  1'b0, 2'd0}, // R2 high byte
    '{16'hA5C3, 16'h2222, 8'h01, 16'd6,  8'd40, 1'b1, 2'd2}, // R5
    '{16'hA5C3, 16'h3333, 8'h07, 16'd3,  8'd1,  1'b0, 2'd0}, // R6 unknown kind
    '{16'hA5C3, 16'h4444, 8'h01, 16'd0,  8'd1,  1'b0, 2'd0}, // R7 zero length
    '{16'hA5C3, 16'h5555, 8'h01, 16'd20, 8'd5,  1'b0, 2'd0}  // R10 overflow
  };

  function automatic logic [7:0] pay(logic [7:0] seed, int i);
    return seed + 8'(i * 7);
  endfunction

  // Bit-serial CRC over fr[0..n-1].
  function automatic logic [31:0] ref_crc(int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < n; k++)
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[31] ^ fr[k][b];
        c = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C11DB7;
      end
    return c;
  endfunction

  task automatic build(input logic [15:0] da, sa, input logic [7:0] typ,
                       input logic [15:0] len, input logic [7:0] seed,
                       input logic bad);
    logic [31:0] c;
    fr[0] = da[15:8]; fr[1] = da[7:0]; fr[2] = sa[15:8]; fr[3] = sa[7:0];
    fr[4] = typ; fr[5] = len[15:8]; fr[6] = len[7:0];
    for (int i = 0; i < int'(len); i++) fr[7+i] = pay(seed, i);
    fr_n = 7 + int'(len);
    c = ref_crc(fr_n);
    if (bad) c = c ^ 32'h00000100;
    fr[fr_n] = c[31:24]; fr[fr_n+1] = c[23:16];
    fr[fr_n+2] = c[15:8]; fr[fr_n+3] = c[7:0];
    fr_n = fr_n + 4;
  endtask

  task automatic send(input int n, input bit with_eof);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_byte = fr[i];
      in_sof = (i == 0); in_eof = with_eof && (i == n-1);
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drain(input int n, input logic [7:0] seed, input string req);
    for (int i = 0; i < n; i++) begin
      chk(!buf_empty && rd_data == pay(seed, i), req, int'(rd_data), int'(pay(seed, i)));
      rd_en = 1;
      @(negedge clk);
      rd_en = 0;
    end
    chk(buf_empty == 1'b1, req, int'(buf_empty), 1);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!frame_ok && !crc_error && buf_empty, "R11", {frame_ok, crc_error, buf_empty}, 1);

    for (int v = 0; v < NV; v++) begin
      build(VEC[v].da, VEC[v].sa, VEC[v].typ, VEC[v].len, VEC[v].seed, VEC[v].bad_crc);
      send(fr_n, 1);
      chk(frame_ok == (VEC[v].outcome == 2'd1), "R4 frame_ok", int'(frame_ok),
          int'(VEC[v].outcome == 2'd1));
      chk(crc_error == (VEC[v].outcome == 2'd2), "R5 crc_error", int'(crc_error),
          int'(VEC[v].outcome == 2'd2));
      if (VEC[v].outcome == 2'd1) begin
        chk(rx_src == VEC[v].sa, "R1 src", int'(rx_src), int'(VEC[v].sa));
        chk(rx_len == VEC[v].len[11:0], "R1 len", int'(rx_len), int'(VEC[v].len));
        chk(rx_kind == VEC[v].typ[1:0], "R6 kind", int'(rx_kind), int'(VEC[v].typ[1:0]));
      end
      if (VEC[v].outcome == 2'd2)
        chk(rx_src == VEC[v].sa, "R5 src", int'(rx_src), int'(VEC[v].sa));
      @(negedge clk);
      chk(!frame_ok && !crc_error, "R4 one-cycle pulse", {frame_ok, crc_error}, 0);
      drain((VEC[v].outcome == 2'd1) ? int'(VEC[v].len) : 0, VEC[v].seed, "R3 buffer");
    end

    // R7: length above 2048
    build(MY_ADDR, 16'h6666, 8'h01, 16'd0, 8'd0, 1'b0);
    fr[5] = 8'h08; fr[6] = 8'h01; fr[7] = 8'h11; fr[8] = 8'h22;
    send(9, 1);
    chk(!frame_ok && !crc_error && buf_empty, "R7 len 2049", {frame_ok, crc_error, buf_empty}, 1);

    // R8: end strobe on the second check byte
    build(MY_ADDR, 16'h7777, 8'h01, 16'd4, 8'd20, 1'b0);
    send(fr_n - 2, 1);
    chk(!frame_ok && !crc_error && buf_empty, "R8 early eof", {frame_ok, crc_error, buf_empty}, 1);

    // R8: no end strobe on the fourth check byte
    build(MY_ADDR, 16'h7777, 8'h01, 16'd4, 8'd20, 1'b0);
    fr[fr_n] = 8'h55;
    send(fr_n + 1, 1);
    chk(!frame_ok && !crc_error && buf_empty, "R8 late eof", {frame_ok, crc_error, buf_empty}, 1);

    // R9: partial frame with a staged byte, then a fresh start
    build(MY_ADDR, 16'h8888, 8'h01, 16'd6, 8'd99, 1'b0);
    send(9, 0);
    build(MY_ADDR, 16'h9999, 8'h02, 16'd3, 8'd50, 1'b0);
    send(fr_n, 1);
    chk(frame_ok && rx_src == 16'h9999, "R9 restart", int'(rx_src), 16'h9999);
    @(negedge clk);
    drain(3, 8'd50, "R9 buffer");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule